// File: doc/BRIEF.md
# Three-Channel Timer Host Register Front End

This block is the processor-facing side of a three-channel interval timer. It sits on an 8-bit bus with a two-bit address, an active-low chip select and active-low read and write strobes. Host writes to the control address carry one of three commands: a channel setup word, a freeze of one channel's count, or a multi-channel read-back that can freeze counts and snapshot status bytes. Writes to a channel address build that channel's initial count, one byte or two bytes at a time.

Reads from a channel address return, in priority order, a frozen status byte, then the frozen count, then the live count. Bytes come in the order the channel's setup word chose. The counting engines are outside the block. They supply each channel's live count, output level and not-yet-loaded flag. They take back the stored setup bits, the assembled count register, and single-cycle pulses that mark a new setup word or a newly completed count.

All bus actions take effect when a strobe is released. The release is seen synchronously in the system clock domain. Read data is presented as a byte plus a valid flag instead of a three-state bus.

Top module: `tmr_host_regif`

## Requirements
- R1: After reset every channel's setup bits read 6'h30 (two-byte format, mode 0, binary), every count register is 0, no pulse is raised, and `rvalid` is low with `rdata` 0.
- R2: With `cs_n` high, a write changes no setup bits and raises no pulse, and a read leaves `rvalid` low.
- R3: A write to address 3 whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are non-zero stores bits 5:0 as that channel's setup bits and raises that channel's `mode_wr` bit for one cycle, in the cycle after the strobe release.
- R4: With format 01 (low byte only) a data write sets the count to {8'h00, data}; with format 10 (high byte only) it sets {data, 8'h00}; either way the channel's `count_load` bit pulses once.
- R5: With format 11 the first data write leaves the count register and `count_load` untouched, and the second sets {second, first} and pulses `count_load`; accesses to other channels may come between the two bytes.
- R6: Unfrozen reads return the live count: format 01 gives the low byte, format 10 the high byte, and format 11 alternates low then high.
- R7: A control write with bits 5:4 = 00 freezes the named channel's count; a further freeze before the value is fully read is ignored; after the full read (one byte, or both bytes in format 11) reads follow the live count again.
- R8: A control write with bits 7:6 = 11 and bit 5 low freezes the count of every channel whose select bit is set (bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2), each under the rule of R7.
- R9: A read-back write with bit 4 low snapshots, for each selected channel, the status byte {output level in bit 7, not-loaded flag in bit 6, setup bits in 5:0}; repeated snapshots before the status is read are ignored; one read returns it and releases it.
- R10: If a channel holds both a status snapshot and a frozen count, the first read returns status, the next read or reads return the frozen count, and later reads return the live count.
- R11: A setup word for a channel resets both its read and write byte order to the low byte and drops any frozen count and status snapshot.
- R12: `rvalid` is high only while `cs_n` and `rd_n` are low on a channel address; a read of address 3 leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel 0..2, or 3 for the control address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not valid |
| rvalid | output | 1 | Read data is being presented |
| live_count | input | 48 | Live counts from the engines, channel i at [16i+15:16i] |
| live_out | input | 3 | Output level of each channel |
| live_null | input | 3 | Per-channel flag: written count not yet loaded |
| mode_byte | output | 18 | Stored setup bits, channel i at [6i+5:6i] |
| count_reg | output | 48 | Assembled count register per channel |
| mode_wr | output | 3 | One-cycle pulse per channel on a setup word |
| count_load | output | 3 | One-cycle pulse per channel when a count is complete |

## Verification
Read data is combinational. It is valid in the same cycle that `rd_n` goes low, so the monitor samples it two time units after the rising edge inside the strobe-low window. Pointer, freeze and snapshot updates land on the clock edge after the strobe release, so the next read already reflects them. Pulses and the count and setup outputs appear one cycle after the release edge, and the driver samples them at that point. Live inputs are changed only between bus accesses, which separates the freeze and snapshot instants from later changes.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = 6;

  typedef enum logic [1:0] {
    FMT_FREEZE = 2'b00,
    FMT_LO     = 2'b01,
    FMT_HI     = 2'b10,
    FMT_BOTH   = 2'b11
  } fmt_e;

  // Reset setup bits: two-byte format, mode 0, binary (R1)
  localparam logic [MODE_W-1:0] MODE_RST = 6'h30;

  // Byte chosen for a read given the format and the read pointer (R6)
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] v,
                                                  input logic [1:0] fmt,
                                                  input logic hi_ptr);
    logic [BYTE_W-1:0] b;
    case (fmt)
      FMT_HI:   b = v[WORD_W-1:BYTE_W];
      FMT_BOTH: b = hi_ptr ? v[WORD_W-1:BYTE_W] : v[BYTE_W-1:0];
      default:  b = v[BYTE_W-1:0];
    endcase
    return b;
  endfunction

  // Completed count from the pending low byte and the final data byte (R4, R5)
  function automatic logic [WORD_W-1:0] merge_count(input logic [1:0] fmt,
                                                    input logic [BYTE_W-1:0] lo_pend,
                                                    input logic [BYTE_W-1:0] d);
    logic [WORD_W-1:0] w;
    case (fmt)
      FMT_LO:  w = {{BYTE_W{1'b0}}, d};
      FMT_HI:  w = {d, {BYTE_W{1'b0}}};
      default: w = {d, lo_pend};
    endcase
    return w;
  endfunction

  // Status snapshot layout (R9)
  function automatic logic [BYTE_W-1:0] status_byte(input logic out_lvl,
                                                    input logic nul,
                                                    input logic [MODE_W-1:0] mode);
    return {out_lvl, nul, mode};
  endfunction
endpackage

// File: rtl/tmr_strobe_edge.sv
module tmr_strobe_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic       wr_evt,
  output logic       rd_evt,
  output logic [1:0] ev_addr,
  output logic [7:0] ev_data
);
  logic rd_q, wr_q, cs_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b1;
      wr_q    <= 1'b1;
      cs_h    <= 1'b1;
      ev_addr <= '0;
      ev_data <= '0;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
      if (!rd_n || !wr_n) begin
        cs_h    <= cs_n;
        ev_addr <= addr;
        ev_data <= wdata;
      end
    end
  end

  // Release of a strobe that was qualified by chip select (R2)
  assign wr_evt = !wr_q && wr_n && !cs_h;
  assign rd_evt = !rd_q && rd_n && !cs_h;
endmodule

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode #(
  parameter int NUM_CH = 3
) (
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [1:0]        ev_addr,
  input  logic [7:1]        ev_ctl,
  output logic [NUM_CH-1:0] cw_hit,
  output logic [NUM_CH-1:0] frz_hit,
  output logic [NUM_CH-1:0] rbc_hit,
  output logic [NUM_CH-1:0] rbs_hit,
  output logic [NUM_CH-1:0] dwr_hit,
  output logic [NUM_CH-1:0] drd_hit
);
  localparam logic [1:0] CTRL_ADDR = 2'b11;
  localparam logic [1:0] RB_SEL    = 2'b11;

  logic       ctrl_wr;
  logic [1:0] sel;
  logic [1:0] fmt;
  logic       rb_cmd;

  assign ctrl_wr = wr_evt && (ev_addr == CTRL_ADDR);
  assign sel     = ev_ctl[7:6];
  assign fmt     = ev_ctl[5:4];
  assign rb_cmd  = ctrl_wr && (sel == RB_SEL);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [1:0] CH = 2'(i);
    // R3 setup word, R7 freeze command
    assign cw_hit[i]  = ctrl_wr && (sel == CH) && (fmt != 2'b00);
    assign frz_hit[i] = ctrl_wr && (sel == CH) && (fmt == 2'b00);
    // R8 / R9 read-back: bit 5 low = count, bit 4 low = status, bit i+1 selects
    assign rbc_hit[i] = rb_cmd && !ev_ctl[5] && ev_ctl[i+1];
    assign rbs_hit[i] = rb_cmd && !ev_ctl[4] && ev_ctl[i+1];
    assign dwr_hit[i] = wr_evt && (ev_addr == CH);
    assign drd_hit[i] = rd_evt && (ev_addr == CH);
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_hit,
  input  logic              frz_hit,
  input  logic              rbc_hit,
  input  logic              rbs_hit,
  input  logic              dwr_hit,
  input  logic              drd_hit,
  input  logic [BYTE_W-1:0] ev_data,
  input  logic [WORD_W-1:0] live_cnt,
  input  logic              live_out,
  input  logic              live_null,
  output logic [MODE_W-1:0] mode_q,
  output logic [WORD_W-1:0] cr_q,
  output logic              mode_pulse,
  output logic              load_pulse,
  output logic [BYTE_W-1:0] rbyte
);
  logic [BYTE_W-1:0] lo_pend;
  logic              wptr, rptr;
  logic              ol_held, st_held;
  logic [WORD_W-1:0] ol_q;
  logic [BYTE_W-1:0] st_q;
  logic [1:0]        fmt;
  logic              freeze_req;

  assign fmt        = mode_q[5:4];
  assign freeze_req = frz_hit || rbc_hit;

  // R10: status first, then frozen count, then live count
  assign rbyte = st_held ? st_q : pick_byte(ol_held ? ol_q : live_cnt, fmt, rptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_RST;
      cr_q       <= '0;
      lo_pend    <= '0;
      wptr       <= 1'b0;
      rptr       <= 1'b0;
      ol_held    <= 1'b0;
      ol_q       <= '0;
      st_held    <= 1'b0;
      st_q       <= '0;
      mode_pulse <= 1'b0;
      load_pulse <= 1'b0;
    end else begin
      mode_pulse <= 1'b0;
      load_pulse <= 1'b0;
      if (cw_hit) begin
        // R3, R11
        mode_q     <= ev_data[MODE_W-1:0];
        wptr       <= 1'b0;
        rptr       <= 1'b0;
        ol_held    <= 1'b0;
        st_held    <= 1'b0;
        mode_pulse <= 1'b1;
      end else begin
        // R7, R8: only the first freeze counts
        if (freeze_req && !ol_held) begin
          ol_q    <= live_cnt;
          ol_held <= 1'b1;
        end
        // R9: only the first snapshot counts
        if (rbs_hit && !st_held) begin
          st_q    <= status_byte(live_out, live_null, mode_q);
          st_held <= 1'b1;
        end
        // R4, R5
        if (dwr_hit) begin
          if (fmt == FMT_BOTH && !wptr) begin
            lo_pend <= ev_data;
            wptr    <= 1'b1;
          end else begin
            cr_q       <= merge_count(fmt, lo_pend, ev_data);
            load_pulse <= 1'b1;
            wptr       <= 1'b0;
          end
        end
        // R6, R7, R10
        if (drd_hit) begin
          if (st_held) begin
            st_held <= 1'b0;
          end else if (fmt == FMT_BOTH) begin
            rptr <= !rptr;
            if (rptr) ol_held <= 1'b0;
          end else begin
            ol_held <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic [1:0]               addr,
  input  logic [NUM_CH*BYTE_W-1:0] rbytes,
  output logic [BYTE_W-1:0]        rdata,
  output logic                     rvalid
);
  // R12
  assign rvalid = !cs_n && !rd_n && (int'(addr) < NUM_CH);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rvalid && int'(addr) == i) rdata = rbytes[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/tmr_host_regif.sv
module tmr_host_regif
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [1:0]               addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  output logic                     rvalid,
  input  logic [NUM_CH*WORD_W-1:0] live_count,
  input  logic [NUM_CH-1:0]        live_out,
  input  logic [NUM_CH-1:0]        live_null,
  output logic [NUM_CH*MODE_W-1:0] mode_byte,
  output logic [NUM_CH*WORD_W-1:0] count_reg,
  output logic [NUM_CH-1:0]        mode_wr,
  output logic [NUM_CH-1:0]        count_load
);
  logic              wr_evt, rd_evt;
  logic [1:0]        ev_addr;
  logic [BYTE_W-1:0] ev_data;
  logic [NUM_CH-1:0] cw_hit, frz_hit, rbc_hit, rbs_hit, dwr_hit, drd_hit;
  logic [NUM_CH*BYTE_W-1:0] rbytes;

  tmr_strobe_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_evt  (wr_evt),
    .rd_evt  (rd_evt),
    .ev_addr (ev_addr),
    .ev_data (ev_data)
  );

  tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_evt  (wr_evt),
    .rd_evt  (rd_evt),
    .ev_addr (ev_addr),
    .ev_ctl  (ev_data[7:1]),
    .cw_hit  (cw_hit),
    .frz_hit (frz_hit),
    .rbc_hit (rbc_hit),
    .rbs_hit (rbs_hit),
    .dwr_hit (dwr_hit),
    .drd_hit (drd_hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tmr_chan_regs u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cw_hit     (cw_hit[i]),
      .frz_hit    (frz_hit[i]),
      .rbc_hit    (rbc_hit[i]),
      .rbs_hit    (rbs_hit[i]),
      .dwr_hit    (dwr_hit[i]),
      .drd_hit    (drd_hit[i]),
      .ev_data    (ev_data),
      .live_cnt   (live_count[i*WORD_W +: WORD_W]),
      .live_out   (live_out[i]),
      .live_null  (live_null[i]),
      .mode_q     (mode_byte[i*MODE_W +: MODE_W]),
      .cr_q       (count_reg[i*WORD_W +: WORD_W]),
      .mode_pulse (mode_wr[i]),
      .load_pulse (count_load[i]),
      .rbyte      (rbytes[i*BYTE_W +: BYTE_W])
    );
  end

  tmr_rd_mux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_mux (
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .addr   (addr),
    .rbytes (rbytes),
    .rdata  (rdata),
    .rvalid (rvalid)
  );
endmodule

// File: rtl/tmr_host_regif_chk.sv
module tmr_host_regif_chk #(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 16,
  parameter int MODE_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        mode_wr,
  input logic [NUM_CH-1:0]        count_load,
  input logic [NUM_CH*MODE_W-1:0] mode_byte,
  input logic [NUM_CH*WORD_W-1:0] count_reg
);
  // R3: a setup word addresses one channel only
  a_r3_one_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_wr));

  // R4: a data write completes at most one count
  a_r4_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(count_load));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R3: pulse lasts a single cycle
    a_r3_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr[i] |=> !mode_wr[i]);
    // R3: setup bits move only with a setup pulse
    a_r3_mode_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_byte[i*MODE_W +: MODE_W]) |-> mode_wr[i]);
    // R5: count register moves only with a completed load
    a_r5_count_moves_with_load: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count_reg[i*WORD_W +: WORD_W]) |-> count_load[i]);
  end
endmodule

bind tmr_host_regif tmr_host_regif_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_wr    (mode_wr),
  .count_load (count_load),
  .mode_byte  (mode_byte),
  .count_reg  (count_reg)
);

// File: tb/tmr_host_regif_bench.sv
module tmr_host_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [47:0] live_count = '0;
  logic [2:0]  live_out = '0, live_null = '0;
  logic [17:0] mode_byte;
  logic [47:0] count_reg;
  logic [2:0]  mode_wr, count_load;

  int checks = 0;
  int errors = 0;
  logic [2:0] s_mode_wr, s_load;
  string      q_req[$];
  logic [7:0] q_val[$];

  always #5 clk = ~clk;

  tmr_host_regif u_tmr_host_regif (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .live_count(live_count), .live_out(live_out), .live_null(live_null),
    .mode_byte(mode_byte), .count_reg(count_reg),
    .mode_wr(mode_wr), .count_load(count_load)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write: strobe low one cycle, sample pulses one cycle after release edge
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic cs);
    @(negedge clk);
    cs_n = cs; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(posedge clk);
    #2;
    s_mode_wr = mode_wr;
    s_load    = count_load;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  // Read: expected byte goes to the scoreboard, the monitor compares it
  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
    q_req.push_back(req);
    q_val.push_back(exp);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic probe_no_read(input logic [1:0] a, input logic cs, input string req);
    @(negedge clk);
    cs_n = cs; addr = a; rd_n = 1'b0;
    @(posedge clk);
    #2;
    check(req, {31'b0, rvalid}, 32'd0);
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  // Monitor: one sample per strobe-low cycle, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (rvalid) begin
      checks++;
      if (q_val.size() == 0) begin
        errors++;
        $display("FAIL R12: unexpected read data actual %h expected none", rdata);
      end else begin
        string r;
        logic [7:0] e;
        r = q_req.pop_front();
        e = q_val.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: read actual %h expected %h", r, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    live_count = {16'h0F0E, 16'hABCD, 16'h1234};
    live_out   = 3'b101;
    live_null  = 3'b010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode0", {26'b0, mode_byte[5:0]}, 32'h30);
    check("R1 mode2", {26'b0, mode_byte[17:12]}, 32'h30);
    check("R1 counts", {16'b0, count_reg[15:0] | count_reg[31:16] | count_reg[47:32]}, 32'h0);
    check("R1 pulses", {26'b0, mode_wr, count_load}, 32'h0);
    check("R1 rvalid", {23'b0, rvalid, rdata}, 32'h0);

    // R2 chip select high
    bus_write(2'b11, 8'h12, 1'b1);
    check("R2 no pulse", {29'b0, s_mode_wr}, 32'h0);
    check("R2 mode kept", {26'b0, mode_byte[5:0]}, 32'h30);
    probe_no_read(2'b00, 1'b1, "R2 read ignored");

    // R3 setup word, R4 single-byte counts
    bus_write(2'b11, 8'h14, 1'b0);
    check("R3 pulse ch0", {29'b0, s_mode_wr}, 32'h1);
    check("R3 mode ch0", {26'b0, mode_byte[5:0]}, 32'h14);
    bus_write(2'b00, 8'h5A, 1'b0);
    check("R4 load ch0", {29'b0, s_load}, 32'h1);
    check("R4 low only", {16'b0, count_reg[15:0]}, 32'h005A);
    bus_write(2'b11, 8'h67, 1'b0);
    check("R3 mode ch1", {26'b0, mode_byte[11:6]}, 32'h27);
    bus_write(2'b01, 8'hC3, 1'b0);
    check("R4 high only", {16'b0, count_reg[31:16]}, 32'hC300);

    // R5 two-byte with interleave
    bus_write(2'b11, 8'hB4, 1'b0);
    check("R3 pulse ch2", {29'b0, s_mode_wr}, 32'h4);
    bus_write(2'b10, 8'h11, 1'b0);
    check("R5 first byte no load", {29'b0, s_load}, 32'h0);
    check("R5 first byte no change", {16'b0, count_reg[47:32]}, 32'h0);
    bus_write(2'b00, 8'h22, 1'b0);
    check("R5 interleaved ch0", {16'b0, count_reg[15:0]}, 32'h0022);
    bus_write(2'b10, 8'h99, 1'b0);
    check("R5 second byte load", {29'b0, s_load}, 32'h4);
    check("R5 assembled", {16'b0, count_reg[47:32]}, 32'h9911);

    // R6 live reads
    bus_read(2'b00, 8'h34, "R6 low only");
    bus_read(2'b01, 8'hAB, "R6 high only");
    bus_read(2'b10, 8'h0E, "R6 two-byte low");
    bus_read(2'b10, 8'h0F, "R6 two-byte high");

    // R7 freeze, repeat ignored, release after full read
    live_count[47:32] = 16'h2233;
    bus_write(2'b11, 8'h80, 1'b0);
    live_count[47:32] = 16'h4455;
    bus_write(2'b11, 8'h80, 1'b0);
    live_count[47:32] = 16'h6677;
    bus_read(2'b10, 8'h33, "R7 frozen low");
    bus_read(2'b10, 8'h22, "R7 frozen high");
    bus_read(2'b10, 8'h77, "R7 released low");
    bus_read(2'b10, 8'h66, "R7 released high");
    bus_write(2'b11, 8'h80, 1'b0);
    live_count[47:32] = 16'h0102;
    bus_read(2'b10, 8'h77, "R7 split low");
    bus_write(2'b00, 8'h01, 1'b0);
    bus_read(2'b10, 8'h66, "R7 split high");

    // R8 read-back count for channels 0 and 2
    bus_write(2'b11, 8'hDA, 1'b0);
    live_count[15:0]  = 16'h9999;
    live_count[47:32] = 16'h8888;
    bus_read(2'b00, 8'h34, "R8 ch0 frozen");
    bus_read(2'b10, 8'h02, "R8 ch2 frozen low");
    bus_read(2'b10, 8'h01, "R8 ch2 frozen high");
    bus_read(2'b00, 8'h99, "R8 ch0 released");

    // R9 status snapshot, repeat ignored
    bus_write(2'b11, 8'hE4, 1'b0);
    live_out  = 3'b111;
    live_null = 3'b000;
    bus_write(2'b11, 8'hE4, 1'b0);
    bus_read(2'b01, 8'h67, "R9 status");
    bus_read(2'b01, 8'hAB, "R9 after status live");

    // R10 status before frozen count
    live_count[47:32] = 16'h8A8B;
    bus_write(2'b11, 8'hC8, 1'b0);
    live_count[47:32] = 16'h1111;
    bus_read(2'b10, 8'hB4, "R10 status first");
    bus_read(2'b10, 8'h8B, "R10 frozen low");
    bus_read(2'b10, 8'h8A, "R10 frozen high");
    bus_read(2'b10, 8'h11, "R10 live low");
    bus_read(2'b10, 8'h11, "R10 live high");

    // R11 setup word resets pointers and freezes
    live_count[47:32] = 16'h5566;
    bus_write(2'b11, 8'h80, 1'b0);
    bus_read(2'b10, 8'h66, "R11 frozen low");
    bus_write(2'b10, 8'h01, 1'b0);
    bus_write(2'b11, 8'hB4, 1'b0);
    check("R11 pulse", {29'b0, s_mode_wr}, 32'h4);
    live_count[47:32] = 16'h7788;
    bus_read(2'b10, 8'h88, "R11 read pointer reset");
    bus_write(2'b10, 8'h02, 1'b0);
    check("R11 write pointer reset", {29'b0, s_load}, 32'h0);
    bus_write(2'b10, 8'h03, 1'b0);
    check("R11 count", {16'b0, count_reg[47:32]}, 32'h0302);

    // R12 control address is not readable
    probe_no_read(2'b11, 1'b0, "R12 addr3 read");
    @(negedge clk);
    check("R12 idle", {23'b0, rvalid, rdata}, 32'h0);
    check("R12 scoreboard drained", q_val.size(), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule